// File: doc/BRIEF.md
# Dual-Channel Interrupt Status and Mask Unit

This unit gathers two interrupt sources for each of two storage channels: the request raised by the attached drive and the request raised by the bus-master DMA engine. It registers their levels as status, lets software mask each channel's contribution to the interrupt pins, and drives the interrupt pins at a programmable polarity. Software sees the status through two byte-wide registers on a small register port. The channel-0 status byte shares its offset with a write-only chip test register.

The test register selects how the pins are used. In legacy mode each channel has its own interrupt pin. In native mode the unmasked requests of both channels are ORed onto pin 0, and pin 1 rests at its inactive level. A test-mode bit forces a request on both channels, so the pins can be exercised without any drive activity. A strap input, which reports whether a legacy header is fitted, is visible in the second status byte.

Top module: `irq_ctl_dual`

## Requirements
- R1: A read at offset 2 returns channel-0 bus-master status in bit 1 and channel-0 drive status in bit 0. The other bits read as 0.
- R2: A read at offset 3 returns the strap in bit 4, channel-1 bus-master status in bit 3, channel-1 drive status in bit 2, the channel-1 mask in bit 1 and the channel-0 mask in bit 0. Bits 7:5 read as 0, and offsets 0 and 1 read as 0.
- R3: After reset both masks are 0, the unit is in native mode and test mode is off.
- R4: Each status bit equals its request input as sampled at the previous clock edge. A mask bit never changes a status bit.
- R5: A channel whose mask bit is 1 contributes no request to any pin.
- R6: In legacy mode, pin c carries only the request of channel c.
- R7: In native mode, pin 0 carries the OR of both channels' unmasked requests, and pin 1 stays at its inactive level.
- R8: With pol_low[c] = 0 pin c is high when active. With pol_low[c] = 1 it is low when active. In both cases the inactive level equals pol_low[c].
- R9: A write to offset 2 updates the test register only when data bit 7 is 1. In that case bit 1 selects legacy (1) or native (0) mode and bit 0 enables test mode. A write with bit 7 at 0 changes nothing.
- R10: While test mode is on, both channels present a request regardless of their inputs. Masks still apply.
- R11: A write to offset 3 loads only the two mask bits from data bits 1:0. Writes to offsets 0 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register offset for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| drv_irq | input | 2 | Drive interrupt request, one per channel |
| bm_irq | input | 2 | Bus-master interrupt request, one per channel |
| legacy_hdr | input | 1 | Legacy header presence strap |
| pol_low | input | 2 | Per-pin polarity, 1 = active low |
| irq_out | output | 2 | Interrupt pins |

## Verification
The bench targets the corners where the two pin modes differ. It routes a channel-1 request in native mode: a design that skipped the OR would leave pin 0 idle, and one that used pin 1 would toggle the wrong pin. It masks one channel while the other is active and sets active-low polarity on an idle pin, which catches inverted mask or polarity logic because the pin would sit at the wrong rest level. It also writes the test register with bit 7 clear and reads status while masks are set. A design that ignored the guard bit would switch modes, and a design that gated status with the mask would read back zeros.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NCH    = 2;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] OFS_STAT0 = 2'd2;  // status ch0 / test register
  localparam logic [ADDR_W-1:0] OFS_STAT1 = 2'd3;  // status ch1 / masks

  // pin level from request and polarity (pol=1: active low)
  function automatic logic pin_level(input logic active, input logic pol);
    return active ^ pol;
  endfunction

  function automatic logic [REG_W-1:0] pack_stat0(input logic bm0, input logic drv0);
    return {6'b0, bm0, drv0};
  endfunction

  function automatic logic [REG_W-1:0] pack_stat1(input logic strap, input logic bm1,
                                                  input logic drv1, input logic [1:0] msk);
    return {3'b0, strap, bm1, drv1, msk};
  endfunction
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] drv_in,
  input  logic [NCH-1:0] bm_in,
  output logic [NCH-1:0] drv_st,
  output logic [NCH-1:0] bm_st
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        drv_st[c] <= 1'b0;
        bm_st[c]  <= 1'b0;
      end else begin
        drv_st[c] <= drv_in[c];
        bm_st[c]  <= bm_in[c];
      end
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              key_bit,
  input  logic [1:0]        low_bits,
  output logic [NCH-1:0]    mask,
  output logic              legacy,
  output logic              test_on,
  output logic              tst_wr_ok,
  output logic              msk_wr
);
  assign tst_wr_ok = wr && (addr == OFS_STAT0) && key_bit;
  assign msk_wr    = wr && (addr == OFS_STAT1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      legacy  <= 1'b0;
      test_on <= 1'b0;
    end else if (tst_wr_ok) begin
      legacy  <= low_bits[1];
      test_on <= low_bits[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else if (msk_wr) mask <= low_bits[NCH-1:0];
  end
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0] drv_st,
  input  logic [NCH-1:0] bm_st,
  input  logic [NCH-1:0] mask,
  input  logic           legacy,
  input  logic           test_on,
  input  logic [NCH-1:0] pol_low,
  output logic [NCH-1:0] req,
  output logic [NCH-1:0] irq_out
);
  for (genvar c = 0; c < NCH; c++) begin : g_req
    assign req[c] = (drv_st[c] | bm_st[c] | test_on) & ~mask[c];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_pin
    if (c == 0) begin : g_shared
      assign irq_out[c] = pin_level(legacy ? req[c] : (|req), pol_low[c]);
    end else begin : g_own
      assign irq_out[c] = pin_level(legacy & req[c], pol_low[c]);
    end
  end
endmodule

// File: rtl/irq_ctl_dual.sv
module irq_ctl_dual
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [1:0]        drv_irq,
  input  logic [1:0]        bm_irq,
  input  logic              legacy_hdr,
  input  logic [1:0]        pol_low,
  output logic [1:0]        irq_out
);
  logic [NCH-1:0] drv_st, bm_st, mask, req;
  logic           legacy, test_on, tst_wr_ok, msk_wr;

  irq_capture #(.NCH(NCH)) u_cap (
    .clk(clk), .rst_n(rst_n), .drv_in(drv_irq), .bm_in(bm_irq),
    .drv_st(drv_st), .bm_st(bm_st)
  );

  irq_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .key_bit(reg_wdata[7]), .low_bits(reg_wdata[1:0]),
    .mask(mask), .legacy(legacy), .test_on(test_on),
    .tst_wr_ok(tst_wr_ok), .msk_wr(msk_wr)
  );

  irq_route #(.NCH(NCH)) u_route (
    .drv_st(drv_st), .bm_st(bm_st), .mask(mask), .legacy(legacy),
    .test_on(test_on), .pol_low(pol_low), .req(req), .irq_out(irq_out)
  );

  always_comb begin
    case (reg_addr)
      OFS_STAT0: reg_rdata = pack_stat0(bm_st[0], drv_st[0]);
      OFS_STAT1: reg_rdata = pack_stat1(legacy_hdr, bm_st[1], drv_st[1], mask);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctl_dual_chk.sv
module irq_ctl_dual_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] drv_irq,
  input logic [1:0] bm_irq,
  input logic [1:0] pol_low,
  input logic [1:0] irq_out,
  input logic [1:0] drv_st,
  input logic [1:0] bm_st,
  input logic [1:0] mask,
  input logic       legacy,
  input logic       test_on,
  input logic       tst_wr_ok,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata
);
  // R4: status tracks inputs one edge later
  a_r4_status_follow: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (drv_st == $past(drv_irq)) && (bm_st == $past(bm_irq)));

  // R9: write with guard bit clear leaves mode and test unchanged
  a_r9_guard_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && !reg_wdata[7]) |=> $stable(legacy) && $stable(test_on));

  // R5: masked channel in legacy mode rests at its inactive level
  a_r5_masked_idle0: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy && mask[0]) |-> irq_out[0] == pol_low[0]);
  a_r5_masked_idle1: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy && mask[1]) |-> irq_out[1] == pol_low[1]);

  // R7: pin 1 idles in native mode
  a_r7_native_pin1: assert property (@(posedge clk) disable iff (!rst_n)
    !legacy |-> irq_out[1] == pol_low[1]);

  // R10: test mode with no masks asserts shared pin
  a_r10_test_force: assert property (@(posedge clk) disable iff (!rst_n)
    (test_on && !legacy && mask == 2'b00) |-> irq_out[0] == !pol_low[0]);

  // R9: accepted test write updates mode on the next edge
  a_r9_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    tst_wr_ok |=> legacy == $past(reg_wdata[1]));
endmodule

bind irq_ctl_dual irq_ctl_dual_chk i_chk (
  .clk(clk), .rst_n(rst_n), .drv_irq(drv_irq), .bm_irq(bm_irq),
  .pol_low(pol_low), .irq_out(irq_out), .drv_st(drv_st), .bm_st(bm_st),
  .mask(mask), .legacy(legacy), .test_on(test_on), .tst_wr_ok(tst_wr_ok),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/test_irq_ctl_dual.sv
module test_irq_ctl_dual;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] drv_irq = '0, bm_irq = '0, pol_low = '0, irq_out;
  logic       legacy_hdr = 1'b0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_ctl_dual i_irq_ctl_dual (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drv_irq(drv_irq),
    .bm_irq(bm_irq), .legacy_hdr(legacy_hdr), .pol_low(pol_low), .irq_out(irq_out)
  );

  // {drv[1:0], bm[1:0], mask[1:0], legacy, pol[1:0], expected irq_out[1:0]}
  localparam int NV = 12;
  localparam logic [10:0] VEC [NV] = '{
    {2'b00, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00},
    {2'b01, 2'b00, 2'b00, 1'b0, 2'b00, 2'b01},
    {2'b10, 2'b00, 2'b00, 1'b0, 2'b00, 2'b01},
    {2'b10, 2'b00, 2'b01, 1'b0, 2'b00, 2'b01},
    {2'b10, 2'b00, 2'b10, 1'b0, 2'b00, 2'b00},
    {2'b00, 2'b10, 2'b00, 1'b1, 2'b00, 2'b10},
    {2'b01, 2'b10, 2'b01, 1'b1, 2'b00, 2'b10},
    {2'b00, 2'b00, 2'b00, 1'b1, 2'b11, 2'b11},
    {2'b00, 2'b01, 2'b00, 1'b1, 2'b11, 2'b10},
    {2'b00, 2'b01, 2'b00, 1'b0, 2'b01, 2'b00},
    {2'b11, 2'b11, 2'b11, 1'b1, 2'b00, 2'b00},
    {2'b00, 2'b00, 2'b00, 1'b0, 2'b10, 2'b10}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    chk("R3 pins", {6'b0, irq_out}, 8'h00);
    rd_reg(2'd3, r); chk("R3 masks", r, 8'h00);
    rd_reg(2'd2, r); chk("R1 reset", r, 8'h00);
    drv_irq = 2'b10;
    @(negedge clk);
    chk("R3 native default", {6'b0, irq_out}, 8'h01);
    drv_irq = 2'b00;

    legacy_hdr = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [1:0] vd, vb, vm, vp, ve;
      logic       vl;
      {vd, vb, vm, vl, vp, ve} = VEC[i];
      @(negedge clk);
      drv_irq = vd; bm_irq = vb; pol_low = vp;
      wr_reg(2'd3, {6'b0, vm});
      wr_reg(2'd2, {1'b1, 5'b0, vl, 1'b0});
      @(negedge clk);
      chk($sformatf("R5 R6 R7 R8 vec%0d", i), {6'b0, irq_out}, {6'b0, ve});
      rd_reg(2'd2, r); chk($sformatf("R1 vec%0d", i), r, {6'b0, vb[0], vd[0]});
      rd_reg(2'd3, r); chk($sformatf("R2 R4 vec%0d", i), r, {3'b0, 1'b1, vb[1], vd[1], vm});
    end

    // R9: guard bit clear is ignored (stay legacy)
    pol_low = 2'b00; bm_irq = 2'b00; drv_irq = 2'b10;
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd2, 8'h82);
    wr_reg(2'd2, 8'h00);
    @(negedge clk);
    chk("R9 guard ignored", {6'b0, irq_out}, 8'h02);
    // R11: offsets 0 and 1 writes have no effect; high bits at offset 3 ignored
    wr_reg(2'd0, 8'hFF);
    wr_reg(2'd1, 8'hFF);
    @(negedge clk);
    chk("R11 other offsets", {6'b0, irq_out}, 8'h02);
    rd_reg(2'd3, r); chk("R11 masks kept", r, 8'h14);
    rd_reg(2'd0, r); chk("R2 offset0 zero", r, 8'h00);
    wr_reg(2'd3, 8'hFC);
    rd_reg(2'd3, r); chk("R11 high bits dropped", r, 8'h14);
    // R4: mask does not hide status
    wr_reg(2'd3, 8'h03);
    rd_reg(2'd3, r); chk("R4 status under mask", r, 8'h17);
    chk("R5 both masked", {6'b0, irq_out}, 8'h00);
    // R10: test mode forces requests, native
    drv_irq = 2'b00;
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd2, 8'h81);
    @(negedge clk);
    chk("R10 test native", {6'b0, irq_out}, 8'h01);
    wr_reg(2'd2, 8'h83);
    @(negedge clk);
    chk("R10 test legacy", {6'b0, irq_out}, 8'h03);
    wr_reg(2'd3, 8'h02);
    @(negedge clk);
    chk("R10 mask applies", {6'b0, irq_out}, 8'h01);
    // R4: one-cycle latency
    wr_reg(2'd2, 8'h82);
    wr_reg(2'd3, 8'h00);
    @(negedge clk);
    bm_irq = 2'b01;
    #0.5;
    rd_reg(2'd2, r); chk("R4 before edge", r, 8'h00);
    @(negedge clk);
    rd_reg(2'd2, r); chk("R4 after edge", r, 8'h02);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule